// File: doc/BRIEF.md
# Mode-Controlled Bidirectional Shift Register

This block is a small register of stages that either shifts data in serially, from the low stage toward the high stage, or takes a whole word from a set of parallel inputs. A single mode input selects which of these happens. The same mode input also selects which of two strobe inputs the register answers. The right-shift strobe is honoured only in mode 0. The load strobe is honoured only in mode 1. Each strobe acts on its falling transition. Both strobes are ordinary signals sampled in one system clock domain, so a strobe edge is seen one edge of the system clock after the strobe goes low.

In mode 1, shifting toward the low stage is done the usual way with such a register: each stage's output is wired back to the parallel input of the stage below it, and the serial bit is fed to the top stage's parallel input. The left-shifted output is then the lowest stage. To save that external wiring, a `shift_left_i` control gives the same move internally, with its own serial input. With mode held at 1 and the load strobe used, the register also works as a plain word store. Every stage output is visible at all times.

The reset input is active low and asynchronous. It must be released in step with the system clock by a reset synchroniser placed ahead of the block.

Top module: `mode_shift_reg`

## Requirements
- R1: While `rst_n` is low, every stage output `q_o` is 0.
- R2: With `mode_i` = 0, a falling transition of `strobe_r_i` moves each stage `q_o[i]` into `q_o[i+1]` and puts `ser_i` into `q_o[0]`. The new value appears on the system clock edge that first samples `strobe_r_i` low after it was sampled high.
- R3: With `mode_i` = 1 and `shift_left_i` = 0, a falling transition of `strobe_p_i` copies `par_i` into `q_o`, bit for bit, with the same one-edge timing as R2.
- R4: Only a high-to-low transition counts as a strobe event. A strobe that rises, stays low or stays high produces no further change.
- R5: A falling transition on the strobe that does not belong to the current mode leaves `q_o` unchanged. This means `strobe_p_i` in mode 0 and `strobe_r_i` in mode 1.
- R6: In mode 0, `par_i`, `shift_left_i` and `left_ser_i` have no effect. In mode 1, `ser_i` has no effect.
- R7: If `strobe_r_i` and `strobe_p_i` are driven together, the operation is set by `mode_i` alone: a right shift in mode 0 and a load in mode 1.
- R8: With `mode_i` = 1 and `shift_left_i` = 1, a falling transition of `strobe_p_i` moves each `q_o[i+1]` into `q_o[i]` and puts `left_ser_i` into `q_o[WIDTH-1]`. The result equals a load of `par_i` = {`left_ser_i`, `q_o[WIDTH-1:1]`}, which is what the external feedback wiring gives.
- R9: When neither strobe has a falling transition, `q_o` holds its value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_i | input | 1 | 0: right shift on `strobe_r_i`; 1: load or left shift on `strobe_p_i` |
| strobe_r_i | input | 1 | Right-shift strobe, active on its falling transition |
| strobe_p_i | input | 1 | Load strobe, active on its falling transition |
| ser_i | input | 1 | Serial bit entering stage 0 during a right shift |
| shift_left_i | input | 1 | In mode 1, selects the internal left shift instead of the parallel load |
| left_ser_i | input | 1 | Serial bit entering the top stage during an internal left shift |
| par_i | input | WIDTH | Parallel word; bit i goes to stage i |
| q_o | output | WIDTH | Stage outputs; bit 0 is the first stage, which is also the left-shift output |

## Verification
Every cycle, the assertions check the next value of the register against each kind of strobe event: right shift, load, internal left shift, a strobe on the wrong mode, and no event at all. They also check that the outputs are zero during reset. Other behaviours can only be shown by the bench's scenarios. These are the equivalence of the internal left shift with the wired feedback load, tied strobes, strobes held low across several cycles, and inputs that are ignored in each mode. The bench shows each of them by watching `q_o` after a directed sequence.

// File: rtl/msr_pkg.sv
package msr_pkg;

  // Operation applied to the stage array on one system clock edge
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_SHR  = 2'd1,
    OP_LOAD = 2'd2,
    OP_SHL  = 2'd3
  } msr_op_e;

endpackage

// File: rtl/msr_fall_det.sv
module msr_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  output logic fall_o
);

  logic prev_q;
  logic prev_d;

  // Next-state: remember the strobe level seen on this edge
  always_comb begin
    prev_d = strobe_i;
  end

  // Reset to 0 so that no event is seen on the first edge after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
    end
  end

  assign fall_o = prev_q & ~strobe_i;

endmodule

// File: rtl/msr_op_sel.sv
module msr_op_sel
  import msr_pkg::*;
(
  input  logic    mode_i,
  input  logic    fall_r_i,
  input  logic    fall_p_i,
  input  logic    shift_left_i,
  output msr_op_e op_o
);

  // The mode picks both the data path and the strobe that is honoured
  always_comb begin
    op_o = OP_HOLD;
    if (!mode_i) begin
      if (fall_r_i) begin
        op_o = OP_SHR;
      end
    end else begin
      if (fall_p_i) begin
        op_o = shift_left_i ? OP_SHL : OP_LOAD;
      end
    end
  end

endmodule

// File: rtl/msr_stage_array.sv
module msr_stage_array
  import msr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  msr_op_e          op_i,
  input  logic             ser_i,
  input  logic             left_ser_i,
  input  logic [WIDTH-1:0] par_i,
  output logic [WIDTH-1:0] q_o
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] stage_q;
  logic [WIDTH-1:0] stage_d;
  logic             stage_en;

  assign stage_en = (op_i != OP_HOLD);

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic from_below;
    logic from_above;

    if (i == 0) begin : g_low_end
      assign from_below = ser_i;
    end else begin : g_low_mid
      assign from_below = stage_q[i-1];
    end

    if (i == MSB) begin : g_high_end
      assign from_above = left_ser_i;
    end else begin : g_high_mid
      assign from_above = stage_q[i+1];
    end

    // Next-state for this stage
    always_comb begin
      unique case (op_i)
        OP_SHR:  stage_d[i] = from_below;
        OP_LOAD: stage_d[i] = par_i[i];
        OP_SHL:  stage_d[i] = from_above;
        default: stage_d[i] = stage_q[i];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else if (stage_en) begin
      stage_q <= stage_d;
    end
  end

  assign q_o = stage_q;

endmodule

// File: rtl/mode_shift_reg.sv
module mode_shift_reg
  import msr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_i,
  input  logic             strobe_r_i,
  input  logic             strobe_p_i,
  input  logic             ser_i,
  input  logic             shift_left_i,
  input  logic             left_ser_i,
  input  logic [WIDTH-1:0] par_i,
  output logic [WIDTH-1:0] q_o
);

  logic    fall_r;
  logic    fall_p;
  msr_op_e op;

  msr_fall_det u_fall_r (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (strobe_r_i),
    .fall_o   (fall_r)
  );

  msr_fall_det u_fall_p (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (strobe_p_i),
    .fall_o   (fall_p)
  );

  msr_op_sel u_op_sel (
    .mode_i       (mode_i),
    .fall_r_i     (fall_r),
    .fall_p_i     (fall_p),
    .shift_left_i (shift_left_i),
    .op_o         (op)
  );

  msr_stage_array #(
    .WIDTH (WIDTH)
  ) u_stages (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_i       (op),
    .ser_i      (ser_i),
    .left_ser_i (left_ser_i),
    .par_i      (par_i),
    .q_o        (q_o)
  );

endmodule

// File: rtl/msr_chk.sv
module msr_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_i,
  input logic             strobe_r_i,
  input logic             strobe_p_i,
  input logic             ser_i,
  input logic             shift_left_i,
  input logic             left_ser_i,
  input logic [WIDTH-1:0] par_i,
  input logic [WIDTH-1:0] q_o
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> q_o == '0);

  // R2
  shift_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !mode_i && $fell(strobe_r_i))
    |=> q_o == $past({q_o[WIDTH-2:0], ser_i}));

  // R3
  par_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && mode_i && !shift_left_i && $fell(strobe_p_i))
    |=> q_o == $past(par_i));

  // R8
  shift_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && mode_i && shift_left_i && $fell(strobe_p_i))
    |=> q_o == $past({left_ser_i, q_o[WIDTH-1:1]}));

  // R5
  wrong_strobe_m0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !mode_i && $fell(strobe_p_i) && !$fell(strobe_r_i))
    |=> $stable(q_o));

  // R5
  wrong_strobe_m1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && mode_i && $fell(strobe_r_i) && !$fell(strobe_p_i))
    |=> $stable(q_o));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$fell(strobe_r_i) && !$fell(strobe_p_i))
    |=> $stable(q_o));

endmodule

bind mode_shift_reg msr_chk #(.WIDTH(WIDTH)) u_msr_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_i       (mode_i),
  .strobe_r_i   (strobe_r_i),
  .strobe_p_i   (strobe_p_i),
  .ser_i        (ser_i),
  .shift_left_i (shift_left_i),
  .left_ser_i   (left_ser_i),
  .par_i        (par_i),
  .q_o          (q_o)
);

// File: tb/tb_mode_shift_reg.sv
module tb_mode_shift_reg;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 4;
  localparam int NVEC       = 22;

  typedef struct packed {
    logic         mode;
    logic         sr;
    logic         sp;
    logic         ser;
    logic         shl;
    logic         lser;
    logic [W-1:0] par;
    logic [W-1:0] exp;
    logic [3:0]   req;
  } vec_t;

  // Fields: mode, strobe_r, strobe_p, ser, shift_left, left_ser, par, expected q, requirement
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'b0000, 4'b0001, 4'd2}, // R2 first shift
    '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b0001, 4'd4}, // R4 rising edge
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b0010, 4'd2}, // R2 shift a zero
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'b0000, 4'b0010, 4'd4}, // R4 held low
    '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'b0000, 4'b0010, 4'd4}, // R4 rise again
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'b1111, 4'b0101, 4'd6}, // R6 par and shl ignored
    '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b0101, 4'd9}, // R9 idle
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b1010, 4'b0101, 4'd5}, // R5 load strobe in mode 0
    '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'b1010, 4'b0101, 4'd9}, // R9 idle
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'b1001, 4'b1001, 4'd3}, // R3 load
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'b0000, 4'b1001, 4'd9}, // R9 idle
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'b0110, 4'b1001, 4'd5}, // R5 shift strobe in mode 1
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0110, 4'b1001, 4'd9}, // R9 idle
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0110, 4'b0110, 4'd7}, // R7 tied strobes, mode 1
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b0110, 4'd9}, // R9 idle
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'b1111, 4'b1101, 4'd7}, // R7 tied strobes, mode 0
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b1101, 4'd9}, // R9 idle
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'b0000, 4'b0110, 4'd8}, // R8 left shift, zero in
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'b0000, 4'b0110, 4'd9}, // R9 idle
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'b0000, 4'b1011, 4'd8}, // R8 left shift, one in
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b1011, 4'd9}, // R9 idle
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0101, 4'b0101, 4'd8}  // R8 wired feedback load
  };

  logic         clk;
  logic         rst_n;
  logic         mode_i;
  logic         strobe_r_i;
  logic         strobe_p_i;
  logic         ser_i;
  logic         shift_left_i;
  logic         left_ser_i;
  logic [W-1:0] par_i;
  logic [W-1:0] q_o;

  int n_tests;
  int n_fail;
  bit done;

  mode_shift_reg #(.WIDTH(W)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode_i),
    .strobe_r_i   (strobe_r_i),
    .strobe_p_i   (strobe_p_i),
    .ser_i        (ser_i),
    .shift_left_i (shift_left_i),
    .left_ser_i   (left_ser_i),
    .par_i        (par_i),
    .q_o          (q_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: q_o=%b expected=%b", tag, act, exp);
    end
  endtask

  // Drive inputs just after a falling clock edge; return at the next falling edge
  task automatic step(input logic m, input logic sr, input logic sp, input logic s,
                      input logic shl, input logic ls, input logic [W-1:0] p);
    mode_i       = m;
    strobe_r_i   = sr;
    strobe_p_i   = sp;
    ser_i        = s;
    shift_left_i = shl;
    left_ser_i   = ls;
    par_i        = p;
    @(negedge clk);
  endtask

  task automatic load_word(input logic [W-1:0] p);
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, p);
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, p);
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, p);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: q_o=%b expected=completion", q_o);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] seed;
    logic [W-1:0] via_int;
    logic [W-1:0] via_ext;
    n_tests = 0;
    n_fail  = 0;
    done    = 1'b0;
    rst_n        = 1'b0;
    mode_i       = 1'b0;
    strobe_r_i   = 1'b1;
    strobe_p_i   = 1'b1;
    ser_i        = 1'b1;
    shift_left_i = 1'b0;
    left_ser_i   = 1'b1;
    par_i        = '1;
    repeat (3) @(negedge clk);
    check("R1 reset state", q_o, '0);
    rst_n = 1'b1;
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0);
    check("R1 after release", q_o, '0);

    for (int k = 0; k < NVEC; k++) begin
      step(VECS[k].mode, VECS[k].sr, VECS[k].sp, VECS[k].ser,
           VECS[k].shl, VECS[k].lser, VECS[k].par);
      n_tests++;
      if (q_o !== VECS[k].exp) begin
        n_fail++;
        $display("FAIL R%0d vector %0d: q_o=%b expected=%b", VECS[k].req, k, q_o, VECS[k].exp);
      end
    end

    // R9: strobes steady high, every other input toggling
    load_word(4'b1010);
    check("R3 load before idle", q_o, 4'b1010);
    for (int k = 0; k < 6; k++) begin
      step(k[0], 1'b1, 1'b1, ~k[1], k[0], k[1], 4'(k * 5));
      check("R9 idle with toggling inputs", q_o, 4'b1010);
    end

    // R6: ser ignored in mode 1 load
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'b0000);
    check("R6 ser ignored in mode 1", q_o, 4'b0000);
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000);

    // R8: internal left shift against the wired feedback load
    for (int k = 0; k < 4; k++) begin
      seed = 4'(3 * k + 5);
      load_word(seed);
      step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, k[0], '0);
      via_int = q_o;
      step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0);
      load_word(seed);
      step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, {k[0], q_o[W-1:1]});
      via_ext = q_o;
      step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0);
      check("R8 internal left shift value", via_int, {k[0], seed[W-1:1]});
      check("R8 internal equals wired", via_int, via_ext);
    end

    // R1: asynchronous reset in mid operation
    load_word(4'b1111);
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    check("R1 async reset mid run", q_o, '0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0);
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, '0);
    check("R2 shift after reset", q_o, 4'b0001);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule